// File: doc/BRIEF.md
# Guarded Nonvolatile Byte Update Sequencer

This block rewrites one byte of a 256-entry, 8-bit nonvolatile array, which is modelled here as a register array. A request carries an address, the new data value and a start strobe, together with an enable that comes from the security logic. The block compares the byte already stored with the new value. An erase phase runs only when some bit has to rise from 0 to 1. A write phase runs only when some bit has to fall from 1 to 0. Each phase is held for a parameterised number of clock cycles, so the physical programming time of a few milliseconds can be matched to the clock rate.

The lowest 32 addresses are each covered by a one-time guard bit with the same index. A guard bit starts at 1. A request with `prog_guard` high clears it after one programming phase, and nothing can set it again. While the guard bit of a low address is 0, data updates to that byte are refused. A refused request raises `rejected` for one cycle and leaves the array untouched. A synchronous read port returns a stored byte and its guard bit, so that the surrounding logic can read the array.

Top module: `eeprom_byte_updater`

## Requirements
- R1: After reset, `busy`, `done` and `rejected` are low. At power-up every byte reads 8'hFF and every guard bit reads 1. Reset changes neither the array nor the guard bits.
- R2: An erase phase runs exactly when the new value has a 1 in a position where the stored byte has a 0. At its end the byte holds 8'hFF.
- R3: A write phase runs exactly when some bit must fall from 1 to 0, measured against the byte as it stands when the phase begins: 8'hFF after an erase, otherwise the stored byte. It only clears bits. When the update completes, the byte equals the new value.
- R4: Each phase lasts PHASE_CYC clock cycles, and an erase always comes before a write. `busy` rises in the cycle after an accepted start and stays high for exactly (number of phases × PHASE_CYC) cycles.
- R5: `done` is high for one cycle, in the cycle in which `busy` falls. When no phase is needed, `busy` stays low and `done` is high in the cycle after the start.
- R6: A start with `sec_en` low is refused. `rejected` is high for one cycle in the cycle after the start, `busy` and `done` stay low, and neither the array nor the guard bits change.
- R7: A data update (`prog_guard`=0) to an address below 32 whose guard bit is 0 is refused as in R6, and the byte keeps its value. Updates to addresses 32 and above, and to low addresses whose guard bit is 1, proceed.
- R8: A guard request (`prog_guard`=1) to an address below 32 whose guard bit is 1 runs one phase of PHASE_CYC cycles and then clears that bit. If the bit is already 0, the request completes with `done` in the next cycle and runs no phase. A guard request to address 32 or above is rejected. A guard bit never returns to 1.
- R9: A start that arrives while `busy` is high is ignored.
- R10: `rd_data` and `rd_guard` show the byte at `rd_addr` and its guard bit one cycle after `rd_addr` is presented. `rd_guard` reads 1 for addresses 32 and above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the sequencer |
| start | input | 1 | Request strobe, sampled only while idle |
| prog_guard | input | 1 | 1 = clear the guard bit of `addr`; 0 = update the data byte |
| sec_en | input | 1 | Security enable; when low, requests are refused |
| addr | input | 8 | Target address |
| wdata | input | 8 | New byte value |
| rd_addr | input | 8 | Read port address |
| rd_data | output | 8 | Byte at `rd_addr`, registered |
| rd_guard | output | 1 | Guard bit of `rd_addr` (1 above the guarded range), registered |
| busy | output | 1 | A programming phase is in progress |
| done | output | 1 | One-cycle completion pulse |
| rejected | output | 1 | One-cycle refusal pulse |

## Verification
The assertions rely on the security logic driving `start`, `prog_guard`, `addr` and `wdata` into an idle block. They also rely on power-up array contents, which only a reset-free initial load provides, so the guard bits are assumed never to have been set back to 1 before checking starts. The stimulus changes requests only at falling clock edges and holds `start` for exactly one cycle. It deliberately raises `start` while `busy` is high, because the block has to ignore that pulse. The phase-length bound assumes at most two phases per request, and every request the bench issues stays within that bound.

// File: rtl/eup_pkg.sv
package eup_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ERASE = 2'd1,
    ST_WRITE = 2'd2,
    ST_FUSE  = 2'd3
  } phase_t;
endpackage

// File: rtl/eup_bit_plan.sv
// Decides which programming phases an update needs.
module eup_bit_plan #(
  parameter int W = 8
) (
  input  logic [W-1:0] cur,
  input  logic [W-1:0] nxt,
  output logic         need_erase,
  output logic         need_write
);
  logic [W-1:0] rise_bits;
  logic [W-1:0] base;

  always_comb begin
    rise_bits  = ~cur & nxt;
    need_erase = |rise_bits;
    // After an erase the byte is all ones, so the write is judged against that.
    base       = need_erase ? {W{1'b1}} : cur;
    need_write = |(base & ~nxt);
  end
endmodule

// File: rtl/eup_phase_timer.sv
// Counts the length of one programming phase.
module eup_phase_timer #(
  parameter int CYC = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic last
);
  localparam int CW = (CYC > 1) ? $clog2(CYC) : 1;
  localparam logic [CW-1:0] TOP = CW'(CYC - 1);

  logic [CW-1:0] cnt;

  assign last = run && (cnt == TOP);

  always_ff @(posedge clk) begin
    if (rst || !run || last) cnt <= '0;
    else                     cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/eup_otp_bits.sv
// One-time guard bits: loaded to ones at power-up, and can only be cleared.
module eup_otp_bits #(
  parameter int N   = 32,
  parameter int IW  = 5
) (
  input  logic          clk,
  input  logic          clr_en,
  input  logic [IW-1:0] clr_idx,
  output logic [N-1:0]  bits
);
  initial bits = '1;

  always @(posedge clk) begin
    if (clr_en) bits[clr_idx] <= 1'b0;
  end
endmodule

// File: rtl/eeprom_byte_updater.sv
module eeprom_byte_updater #(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 8,
  parameter int PROT_N    = 32,
  parameter int PHASE_CYC = 125000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              prog_guard,
  input  logic              sec_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_guard,
  output logic              busy,
  output logic              done,
  output logic              rejected
);
  import eup_pkg::*;

  localparam int DEPTH = 1 << ADDR_W;
  localparam int PIW   = (PROT_N > 1) ? $clog2(PROT_N) : 1;
  localparam logic [ADDR_W:0] LOW_LIM = (ADDR_W + 1)'(PROT_N);

  phase_t            state;
  logic [ADDR_W-1:0] a_q;
  logic [DATA_W-1:0] d_q;
  logic              wr_after;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PROT_N-1:0] prot_bits;

  logic [DATA_W-1:0] cur_byte;
  logic              low_addr, guard_at;
  logic              need_erase, need_write;
  logic              phase_last;
  logic              mem_we;
  logic [DATA_W-1:0] mem_wd;
  logic              fuse_clr;
  logic              rd_low;

  // Power-up content of the array is the erased state.
  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '1;
  end

  always @(posedge clk) begin
    if (mem_we) mem[a_q] <= mem_wd;
  end

  always_comb begin
    cur_byte = mem[addr];
    low_addr = {1'b0, addr} < LOW_LIM;
    guard_at = prot_bits[addr[PIW-1:0]];
  end

  eup_bit_plan #(.W(DATA_W)) u_plan (
    .cur        (cur_byte),
    .nxt        (wdata),
    .need_erase (need_erase),
    .need_write (need_write)
  );

  eup_phase_timer #(.CYC(PHASE_CYC)) u_timer (
    .clk  (clk),
    .rst  (rst),
    .run  (state != ST_IDLE),
    .last (phase_last)
  );

  eup_otp_bits #(.N(PROT_N), .IW(PIW)) u_guard (
    .clk     (clk),
    .clr_en  (fuse_clr),
    .clr_idx (a_q[PIW-1:0]),
    .bits    (prot_bits)
  );

  always_comb begin
    mem_we   = phase_last && ((state == ST_ERASE) || (state == ST_WRITE));
    mem_wd   = (state == ST_ERASE) ? {DATA_W{1'b1}} : (mem[a_q] & d_q);
    fuse_clr = phase_last && (state == ST_FUSE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      busy     <= 1'b0;
      done     <= 1'b0;
      rejected <= 1'b0;
      a_q      <= '0;
      d_q      <= '0;
      wr_after <= 1'b0;
    end else begin
      done     <= 1'b0;
      rejected <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            a_q <= addr;
            d_q <= wdata;
            if (!sec_en) begin
              rejected <= 1'b1;
            end else if (prog_guard) begin
              if (!low_addr)      rejected <= 1'b1;
              else if (!guard_at) done     <= 1'b1;
              else begin
                state <= ST_FUSE;
                busy  <= 1'b1;
              end
            end else if (low_addr && !guard_at) begin
              rejected <= 1'b1;
            end else if (need_erase) begin
              state    <= ST_ERASE;
              busy     <= 1'b1;
              wr_after <= need_write;
            end else if (need_write) begin
              state <= ST_WRITE;
              busy  <= 1'b1;
            end else begin
              done <= 1'b1;
            end
          end
        end
        ST_ERASE: begin
          if (phase_last) begin
            if (wr_after) state <= ST_WRITE;
            else begin
              state <= ST_IDLE;
              busy  <= 1'b0;
              done  <= 1'b1;
            end
          end
        end
        ST_WRITE, ST_FUSE: begin
          if (phase_last) begin
            state <= ST_IDLE;
            busy  <= 1'b0;
            done  <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Read port, one cycle of latency.
  always_comb rd_low = {1'b0, rd_addr} < LOW_LIM;

  always_ff @(posedge clk) begin
    rd_data  <= mem[rd_addr];
    rd_guard <= rd_low ? prot_bits[rd_addr[PIW-1:0]] : 1'b1;
  end
endmodule

// File: rtl/eup_checks.sv
module eup_checks #(
  parameter int PHASE_CYC = 4,
  parameter int PROT_N    = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              sec_en,
  input logic              busy,
  input logic              done,
  input logic              rejected,
  input logic              mem_we,
  input logic [PROT_N-1:0] prot_bits
);
  int                busy_run;
  logic [PROT_N-1:0] prot_prev;
  logic              armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_run <= 0;
      armed    <= 1'b0;
    end else begin
      busy_run <= busy ? busy_run + 1 : 0;
      armed    <= 1'b1;
    end
    prot_prev <= prot_bits;
  end

  // R5: done is a single-cycle pulse
  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R5: the end of busy is marked by done
  assert_done_at_end_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  // R6: a start with the enable low is refused in the next cycle
  assert_refuse_sec_R6: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && !sec_en) |=> (rejected && !busy && !done));

  // R6: the array is written only while a phase is in progress
  assert_no_idle_write_R6: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> busy);

  // R4: at most two phases per request
  assert_busy_bound_R4: assert property (@(posedge clk) disable iff (rst)
    busy_run <= 2 * PHASE_CYC);

  // R8: a guard bit never returns to 1
  assert_guard_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    armed |-> ((prot_bits & ~prot_prev) == '0));
endmodule

bind eeprom_byte_updater eup_checks #(.PHASE_CYC(PHASE_CYC), .PROT_N(PROT_N)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .sec_en    (sec_en),
  .busy      (busy),
  .done      (done),
  .rejected  (rejected),
  .mem_we    (mem_we),
  .prot_bits (prot_bits)
);

// File: tb/tb_eeprom_byte_updater.sv
`timescale 1ns/1ps
module tb_eeprom_byte_updater;
  localparam int P = 2;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0, prog_guard = 1'b0, sec_en = 1'b1;
  logic [7:0] addr = '0, wdata = '0, rd_addr = '0;
  logic [7:0] rd_data;
  logic       rd_guard, busy, done, rejected;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  eeprom_byte_updater #(.ADDR_W(8), .DATA_W(8), .PROT_N(32), .PHASE_CYC(P)) dut (
    .clk(clk), .rst(rst), .start(start), .prog_guard(prog_guard), .sec_en(sec_en),
    .addr(addr), .wdata(wdata), .rd_addr(rd_addr), .rd_data(rd_data),
    .rd_guard(rd_guard), .busy(busy), .done(done), .rejected(rejected)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic update(input logic [7:0] a, input logic [7:0] d, input bit g, input bit s,
                        output int cyc, output bit dn, output bit rj);
    @(negedge clk);
    addr = a; wdata = d; prog_guard = g; sec_en = s; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    rj = rejected; dn = done; cyc = 0;
    while (busy && cyc < 100) begin
      cyc++;
      @(negedge clk);
      if (done) dn = 1'b1;
    end
    sec_en = 1'b1; prog_guard = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d, output logic g);
    @(negedge clk);
    rd_addr = a;
    @(negedge clk);
    d = rd_data; g = rd_guard;
  endtask

  function automatic int phases(input logic [7:0] o, input logic [7:0] n);
    bit e, w;
    e = (~o & n) != 8'h00;
    w = e ? (n != 8'hFF) : ((o & ~n) != 8'h00);
    return int'(e) + int'(w);
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int cyc; bit dn, rj; logic [7:0] v; logic g;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state of the flags
    chk(!busy && !done && !rejected, "R1 flags", {busy, done, rejected}, 0);
    // R1 / R10: power-up contents over every address
    for (int a = 0; a < 256; a++) begin
      rd(8'(a), v, g);
      chk(v == 8'hFF, "R1 byte", v, 8'hFF);
      chk(g == 1'b1, "R10 guard", g, 1);
    end

    // R2 R3 R4 R5: sweep of old/new pairs on unguarded addresses
    for (int oi = 0; oi < 16; oi++) begin
      for (int nv = 0; nv < 256; nv++) begin
        logic [7:0] o, a, cur;
        o = 8'(oi * 17);
        a = 8'(32 + ((oi * 256 + nv) % 224));
        rd(a, cur, g);
        update(a, o, 0, 1, cyc, dn, rj);
        chk(cyc == P * phases(cur, o) && dn, "R4 setup", cyc, P * phases(cur, o));
        update(a, 8'(nv), 0, 1, cyc, dn, rj);
        chk(cyc == P * phases(o, 8'(nv)), "R2 R3 R4 phase length", cyc, P * phases(o, 8'(nv)));
        chk(dn && !rj, "R5 done", {dn, rj}, 2);
        rd(a, v, g);
        chk(v == 8'(nv), "R3 final byte", v, nv);
      end
    end

    // R5: zero-phase update, done in the cycle after the start
    update(8'd40, 8'h5A, 0, 1, cyc, dn, rj);
    update(8'd40, 8'h5A, 0, 1, cyc, dn, rj);
    chk(cyc == 0 && dn && !rj, "R5 zero phase", cyc, 0);

    // R6: security enable low
    update(8'd40, 8'hA5, 0, 0, cyc, dn, rj);
    chk(rj && !dn && cyc == 0, "R6 refused", {rj, dn}, 2);
    rd(8'd40, v, g);
    chk(v == 8'h5A, "R6 unchanged", v, 8'h5A);
    update(8'd3, 8'h00, 1, 0, cyc, dn, rj);
    rd(8'd3, v, g);
    chk(rj && g == 1'b1, "R6 guard untouched", g, 1);

    // R8: clear the guard bit of address 5 and at the boundary 31
    update(8'd5, 8'h00, 1, 1, cyc, dn, rj);
    chk(cyc == P && dn && !rj, "R8 fuse phase", cyc, P);
    rd(8'd5, v, g);
    chk(g == 1'b0, "R8 guard cleared", g, 0);
    update(8'd31, 8'h00, 1, 1, cyc, dn, rj);
    rd(8'd31, v, g);
    chk(g == 1'b0 && dn, "R8 boundary 31", g, 0);
    update(8'd32, 8'h00, 1, 1, cyc, dn, rj);
    chk(rj && !dn, "R8 addr 32 rejected", rj, 1);
    update(8'd5, 8'h00, 1, 1, cyc, dn, rj);
    chk(cyc == 0 && dn && !rj, "R8 already cleared", cyc, 0);
    rd(8'd5, v, g);
    chk(g == 1'b0, "R8 stays cleared", g, 0);

    // R7: guarded byte refuses updates, neighbours do not
    update(8'd5, 8'h12, 0, 1, cyc, dn, rj);
    chk(rj && !dn && cyc == 0, "R7 refused", {rj, dn}, 2);
    rd(8'd5, v, g);
    chk(v == 8'hFF, "R7 unchanged", v, 8'hFF);
    update(8'd6, 8'h12, 0, 1, cyc, dn, rj);
    rd(8'd6, v, g);
    chk(v == 8'h12 && !rj, "R7 neighbour updates", v, 8'h12);
    update(8'd32, 8'h34, 0, 1, cyc, dn, rj);
    rd(8'd32, v, g);
    chk(v == 8'h34 && !rj, "R7 address 32 unguarded", v, 8'h34);

    // R9: start while busy is ignored
    update(8'd60, 8'hFF, 0, 1, cyc, dn, rj);
    update(8'd61, 8'hFF, 0, 1, cyc, dn, rj);
    update(8'd60, 8'h00, 0, 1, cyc, dn, rj);
    @(negedge clk);
    addr = 8'd60; wdata = 8'h0F; start = 1'b1;
    @(negedge clk);
    start = 1'b0; cyc = 0;
    @(negedge clk);
    addr = 8'd61; wdata = 8'h00; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (busy && cyc < 100) begin cyc++; @(negedge clk); end
    rd(8'd61, v, g);
    chk(v == 8'hFF, "R9 busy start ignored", v, 8'hFF);
    rd(8'd60, v, g);
    chk(v == 8'h0F, "R9 first request completes", v, 8'h0F);

    // R1: reset keeps array and guard bits
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    rd(8'd6, v, g);
    chk(v == 8'h12, "R1 reset keeps byte", v, 8'h12);
    rd(8'd5, v, g);
    chk(g == 1'b0, "R1 reset keeps guard", g, 0);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule